// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block predicts the next fetch address from the current fetch address alone, before the instruction has been decoded. It is a direct-mapped table of control-transfer entries. Each entry holds a valid flag, the complete address of the branch it describes, the address the branch last jumped to, and a two-bit confidence counter. A lookup returns the stored target when the full address matches and the counter leans towards taken. In every other case it returns the sequential address, fetch address plus four.

The execute stage reports each resolved instruction on a resolution port. It sends the instruction's address, whether it is a control transfer, whether it was taken, its real target, and the next address the fetch stage actually used after it. The block compares that used address with the correct one. If they differ, it raises a kill pulse together with the correct address one cycle later. It also trains the matching entry, or allocates a new entry for a taken control transfer that missed.

The lookup side is purely combinational and has no handshake. The resolution port is a valid-only stream: the block accepts one report in every cycle and has no ready signal, so it never applies back-pressure. Upstream logic may present a report in any cycle.

Top module: `btb_predictor`

## Requirements
- R1: The table has 2^IDX_W entries. The entry is selected by address bits [IDX_W+1:2]; the two lowest address bits take no part in the index.
- R2: A lookup hits only if the selected entry is valid and its stored address equals the full fetch address. Another address that selects the same entry misses.
- R3: On a miss, `next_pc` is `fetch_pc`+4 and both `pred_hit` and `pred_taken` are 0.
- R4: On a hit, `pred_taken` equals bit 1 of the entry's counter. `next_pc` is the stored target when that bit is 1, and `fetch_pc`+4 when it is 0.
- R5: The correct next address for a report is `res_target` if `res_taken` is 1, otherwise `res_pc`+4. When `res_valid` is 1 and `res_pred_next` differs from this address, `kill` is 1 in the following cycle and `redirect_pc` equals the correct address. Otherwise `kill` is 0 in the following cycle.
- R6: A report with `res_ctrl`=1 and `res_taken`=1 that misses in the table allocates the selected entry. The new entry is valid, stores `res_pc` and `res_target`, and has counter value 2. A report that is not taken and misses, or any report with `res_ctrl`=0, leaves the table unchanged.
- R7: A control report that hits moves the entry's counter up on taken and down on not taken, saturating at 3 and at 0. The stored target is rewritten only when the report is taken and mispredicted; a correct prediction updates only the counter.
- R8: After reset every entry is invalid, so every lookup misses, and `kill` is 0.
- R9: An update is written at the clock edge that ends the cycle in which it is reported. A lookup in that same cycle, at the same index, sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched |
| next_pc | output | PC_W | Predicted next fetch address |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_taken | output | 1 | Lookup predicts a taken transfer |
| res_valid | input | 1 | A resolution report is present |
| res_ctrl | input | 1 | Reported instruction is a control transfer |
| res_pc | input | PC_W | Address of the reported instruction |
| res_taken | input | 1 | Reported instruction was taken |
| res_target | input | PC_W | Actual target of the reported instruction |
| res_pred_next | input | PC_W | Next address fetch used after it |
| kill | output | 1 | Pulse: the wrongly fetched path must be killed |
| redirect_pc | output | PC_W | Correct fetch address, meaningful with kill |

## Verification
The assertions take for granted that `rst_n` is low for at least one clock edge before any report is made. They also assume that reports with `res_ctrl`=0 carry `res_taken`=0, since a non-control instruction always falls through. The stimulus keeps to both: it holds reset for several cycles, and every non-control report it makes is not taken. Its `res_pred_next` values come from the reference model's own view of the table, which mirrors how a real fetch stage feeds the port. These values are deliberately replaced by wrong ones when a redirect is to be provoked.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_MAX   = 2'b11;
  localparam ctr_t CTR_MIN   = 2'b00;
  localparam ctr_t CTR_ALLOC = 2'b10;

  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == CTR_MAX) ? c : c + 2'd1;
    else       r = (c == CTR_MIN) ? c : c - 2'd1;
    return r;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_valid,
  output logic [PC_W-1:0]  a_tag,
  output logic [PC_W-1:0]  a_tgt,
  output ctr_t             a_ctr,
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_valid,
  output logic [PC_W-1:0]  b_tag,
  output logic [PC_W-1:0]  b_tgt,
  output ctr_t             b_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  ctr_t             wr_ctr
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] vld_q;
  logic [PC_W-1:0]    tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  ctr_t               ctr_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q[e] <= 1'b0;
      else if (sel) vld_q[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[e] <= wr_tag;
        tgt_q[e] <= wr_tgt;
        ctr_q[e] <= wr_ctr;
      end
    end
  end

  always_comb begin
    a_valid = vld_q[a_idx];
    a_tag   = tag_q[a_idx];
    a_tgt   = tgt_q[a_idx];
    a_ctr   = ctr_q[a_idx];
    b_valid = vld_q[b_idx];
    b_tag   = tag_q[b_idx];
    b_tgt   = tgt_q[b_idx];
    b_ctr   = ctr_q[b_idx];
  end
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] pc,
  input  logic            ent_valid,
  input  logic [PC_W-1:0] ent_tag,
  input  logic [PC_W-1:0] ent_tgt,
  input  ctr_t            ent_ctr,
  output logic            hit,
  output logic            taken,
  output logic [PC_W-1:0] next_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  always_comb begin
    hit     = ent_valid && (ent_tag == pc);
    taken   = hit && ctr_says_taken(ent_ctr);
    next_pc = taken ? ent_tgt : pc + STEP;
  end
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic             res_valid,
  input  logic             res_ctrl,
  input  logic [PC_W-1:0]  res_pc,
  input  logic             res_taken,
  input  logic [PC_W-1:0]  res_target,
  input  logic [PC_W-1:0]  res_pred_next,
  input  logic             ent_valid,
  input  logic [PC_W-1:0]  ent_tag,
  input  logic [PC_W-1:0]  ent_tgt,
  input  ctr_t             ent_ctr,
  output logic             mispredict,
  output logic [PC_W-1:0]  correct_next,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [PC_W-1:0]  wr_tag,
  output logic [PC_W-1:0]  wr_tgt,
  output ctr_t             wr_ctr
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic ent_hit;

  always_comb begin
    correct_next = res_taken ? res_target : res_pc + STEP;
    mispredict   = res_valid && (res_pred_next != correct_next);
    ent_hit      = ent_valid && (ent_tag == res_pc);

    wr_idx = res_pc[IDX_W+1:2];
    wr_tag = res_pc;
    wr_tgt = ent_tgt;
    wr_ctr = ent_ctr;
    wr_en  = 1'b0;

    if (res_valid && res_ctrl) begin
      if (ent_hit) begin
        wr_en  = 1'b1;
        wr_ctr = ctr_step(ent_ctr, res_taken);
        if (mispredict && res_taken) wr_tgt = res_target;
      end else if (res_taken) begin
        wr_en  = 1'b1;
        wr_tgt = res_target;
        wr_ctr = CTR_ALLOC;
      end
    end
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] next_pc,
  output logic            pred_hit,
  output logic            pred_taken,
  input  logic            res_valid,
  input  logic            res_ctrl,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic [PC_W-1:0] res_pred_next,
  output logic            kill,
  output logic [PC_W-1:0] redirect_pc
);
  logic             a_valid, b_valid;
  logic [PC_W-1:0]  a_tag, a_tgt, b_tag, b_tgt;
  ctr_t             a_ctr, b_ctr;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [PC_W-1:0]  wr_tag, wr_tgt;
  ctr_t             wr_ctr;
  logic             mispredict;
  logic [PC_W-1:0]  correct_next;

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(fetch_pc[IDX_W+1:2]), .a_valid(a_valid), .a_tag(a_tag),
    .a_tgt(a_tgt), .a_ctr(a_ctr),
    .b_idx(res_pc[IDX_W+1:2]), .b_valid(b_valid), .b_tag(b_tag),
    .b_tgt(b_tgt), .b_ctr(b_ctr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_tgt(wr_tgt), .wr_ctr(wr_ctr)
  );

  btb_lookup #(.PC_W(PC_W)) u_lookup (
    .pc(fetch_pc), .ent_valid(a_valid), .ent_tag(a_tag),
    .ent_tgt(a_tgt), .ent_ctr(a_ctr),
    .hit(pred_hit), .taken(pred_taken), .next_pc(next_pc)
  );

  btb_resolve #(.PC_W(PC_W), .IDX_W(IDX_W)) u_resolve (
    .res_valid(res_valid), .res_ctrl(res_ctrl), .res_pc(res_pc),
    .res_taken(res_taken), .res_target(res_target),
    .res_pred_next(res_pred_next),
    .ent_valid(b_valid), .ent_tag(b_tag), .ent_tgt(b_tgt), .ent_ctr(b_ctr),
    .mispredict(mispredict), .correct_next(correct_next),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_tgt(wr_tgt), .wr_ctr(wr_ctr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kill        <= 1'b0;
      redirect_pc <= '0;
    end else begin
      kill        <= mispredict;
      redirect_pc <= correct_next;
    end
  end
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic [PC_W-1:0] next_pc,
  input logic            pred_hit,
  input logic            pred_taken,
  input logic            res_valid,
  input logic            res_pc_dummy,
  input logic [PC_W-1:0] res_pc,
  input logic            res_taken,
  input logic [PC_W-1:0] res_target,
  input logic [PC_W-1:0] res_pred_next,
  input logic            kill,
  input logic [PC_W-1:0] redirect_pc
);
  logic [PC_W-1:0] want_next;
  assign want_next = res_taken ? res_target : res_pc + PC_W'(4);

  assert_miss_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (next_pc == fetch_pc + PC_W'(4)) && !pred_taken);

  assert_notaken_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_hit && !pred_taken) |-> next_pc == fetch_pc + PC_W'(4));

  assert_kill_on_wrong_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pred_next != want_next) |=> kill && redirect_pc == $past(want_next));

  assert_no_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_pred_next != want_next) |=> !kill);

  assert_ctrl_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_pc_dummy) |-> !res_taken);
endmodule

bind btb_predictor btb_checker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(next_pc),
  .pred_hit(pred_hit), .pred_taken(pred_taken), .res_valid(res_valid),
  .res_pc_dummy(res_ctrl), .res_pc(res_pc), .res_taken(res_taken),
  .res_target(res_target), .res_pred_next(res_pred_next),
  .kill(kill), .redirect_pc(redirect_pc)
);

// File: tb/btb_predictor_tb.sv
`timescale 1ns/1ps
module btb_predictor_tb;
  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int N     = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic [PC_W-1:0] next_pc;
  logic            pred_hit, pred_taken;
  logic            res_valid = 1'b0, res_ctrl = 1'b0, res_taken = 1'b0;
  logic [PC_W-1:0] res_pc = '0, res_target = '0, res_pred_next = '0;
  logic            kill;
  logic [PC_W-1:0] redirect_pc;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference model of the table
  bit          m_vld [N];
  logic [31:0] m_tag [N];
  logic [31:0] m_tgt [N];
  logic [1:0]  m_ctr [N];

  always #2.5 clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .res_valid(res_valid),
    .res_ctrl(res_ctrl), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_pred_next(res_pred_next),
    .kill(kill), .redirect_pc(redirect_pc)
  );

  function automatic int idx_of(input logic [31:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic bit m_hit(input logic [31:0] pc);
    return m_vld[idx_of(pc)] && m_tag[idx_of(pc)] == pc;
  endfunction

  function automatic logic [31:0] m_next(input logic [31:0] pc);
    if (m_hit(pc) && m_ctr[idx_of(pc)][1]) return m_tgt[idx_of(pc)];
    return pc + 32'd4;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] pc, input string req);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    check(next_pc == m_next(pc) && pred_hit == m_hit(pc) &&
          pred_taken == (m_hit(pc) && m_ctr[idx_of(pc)][1]),
          req, next_pc, m_next(pc));
  endtask

  task automatic resolve(input logic [31:0] pc, input bit ctrl, input bit tk,
                         input logic [31:0] tgt, input logic [31:0] pn,
                         input string req);
    logic [31:0] corr;
    bit          exp_kill;
    int          i;
    corr     = tk ? tgt : pc + 32'd4;
    exp_kill = (pn != corr);
    i        = idx_of(pc);
    @(negedge clk);
    res_valid = 1'b1; res_ctrl = ctrl; res_pc = pc; res_taken = tk;
    res_target = tgt; res_pred_next = pn;
    @(negedge clk);
    res_valid = 1'b0;
    #1;
    check(kill == exp_kill, req, 32'(kill), 32'(exp_kill));
    if (exp_kill) check(redirect_pc == corr, req, redirect_pc, corr);
    if (ctrl) begin
      if (m_vld[i] && m_tag[i] == pc) begin
        m_ctr[i] = tk ? (m_ctr[i] == 2'd3 ? 2'd3 : m_ctr[i] + 2'd1)
                      : (m_ctr[i] == 2'd0 ? 2'd0 : m_ctr[i] - 2'd1);
        if (exp_kill && tk) m_tgt[i] = tgt;
      end else if (tk) begin
        m_vld[i] = 1'b1; m_tag[i] = pc; m_tgt[i] = tgt; m_ctr[i] = 2'd2;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, t;
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state, every index misses; R3 sequential address
    #1;
    check(kill == 1'b0, "R8 kill after reset", 32'(kill), 32'd0);
    for (int i = 0; i < N; i++) lookup(32'h0000_1000 + 32'(i * 4), "R8 R3 empty table");

    // R6 allocation, R5 redirect on first taken
    a = 32'h0000_2008; t = 32'h0000_3000;
    resolve(a, 1'b1, 1'b1, t, a + 32'd4, "R6 R5 allocate taken");
    lookup(a, "R4 hit predicts target");
    // R2 alias with same index, different full address
    b = a + 32'h0001_0000;
    lookup(b, "R2 alias misses");
    // R1 neighbour index untouched; low address bits not part of index
    lookup(a + 32'd4, "R1 neighbour index");
    // R6 not-taken miss leaves table alone
    resolve(b, 1'b1, 1'b0, 32'h0, b + 32'd4, "R6 not-taken miss");
    lookup(a, "R6 entry kept after not-taken miss");
    // R6 non-control report leaves table alone
    resolve(a, 1'b0, 1'b0, 32'h0, a + 32'd4, "R6 non-control report");
    lookup(a, "R6 entry kept after non-control");
    // R7 counter falls: 2 -> 1 switches prediction to sequential
    resolve(a, 1'b1, 1'b0, 32'h0, t, "R7 not taken mispredict");
    lookup(a, "R7 R4 weak not taken");
    resolve(a, 1'b1, 1'b0, 32'h0, a + 32'd4, "R7 correct not taken");
    resolve(a, 1'b1, 1'b0, 32'h0, a + 32'd4, "R7 saturate low");
    lookup(a, "R7 saturated low");
    // R7 climbs back: 0 -> 1 -> 2
    resolve(a, 1'b1, 1'b1, t, a + 32'd4, "R7 taken from 0");
    resolve(a, 1'b1, 1'b1, t, a + 32'd4, "R7 taken from 1");
    lookup(a, "R7 R4 taken again");
    // R7 wrong target rewrites target
    resolve(a, 1'b1, 1'b1, 32'h0000_4440, t, "R7 new target");
    lookup(a, "R7 target rewritten");

    // R9 lookup and update on the same index in one cycle
    @(negedge clk);
    fetch_pc = a; res_valid = 1'b1; res_ctrl = 1'b1; res_pc = a; res_taken = 1'b1;
    res_target = 32'h0000_5550; res_pred_next = 32'h0000_4440;
    #1;
    check(next_pc == 32'h0000_4440, "R9 lookup sees old", next_pc, 32'h0000_4440);
    @(negedge clk);
    res_valid = 1'b0;
    #1;
    check(kill == 1'b1 && redirect_pc == 32'h0000_5550, "R9 R5 redirect",
          redirect_pc, 32'h0000_5550);
    m_tgt[idx_of(a)] = 32'h0000_5550;
    m_ctr[idx_of(a)] = (m_ctr[idx_of(a)] == 2'd3) ? 2'd3 : m_ctr[idx_of(a)] + 2'd1;
    lookup(a, "R9 update visible next cycle");

    // sweep over indices, aliases, directions and targets
    for (int n = 0; n < 400; n++) begin
      logic [31:0] pc, tg, pn;
      bit tk, ct;
      pc = 32'h0001_0000 * 32'((n * 7) % 3 + 1) + 32'(((n * 5) % N) * 4);
      tk = ((n * 3) % 4) != 0;
      ct = (n % 11) != 0;
      if (!ct) tk = 1'b0;
      tg = pc + 32'h100 + ((n % 5 == 0) ? 32'd8 : 32'd0);
      lookup(pc, "R2 R4 sweep lookup");
      pn = m_next(pc);
      if (n % 13 == 0) pn = pn + 32'd16;
      resolve(pc, ct, tk, tg, pn, "R5 R6 R7 sweep resolve");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule